// File: doc/BRIEF.md
# Operand and Branch Address Generator

This block turns a decoded addressing mode into a 16-bit memory address for a small CPU that moves bytes and words. A requester presents the mode, the operand size, a base register value, an address/displacement field and the program counter. The block returns the effective address together with a done strobe. For the auto-increment and auto-decrement modes it also returns the updated register value and a write-back enable. An alignment-error flag reports odd word pointers and odd branch displacements. Arithmetic wraps modulo 2^16 and no carry is reported.

Most modes finish in the cycle in which the request is accepted. The memory-indirect mode makes one word read from a synchronous memory port and returns the word read as the branch target. Requests use a valid/ready handshake: a request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` goes low while an indirect fetch is in flight, and a requester that holds `req_valid` high must keep its request stable until it is taken. The result side has no back-pressure. `done` is a one-cycle strobe that the consumer must take when it appears. Mode codes: 0 post-increment, 1 pre-decrement, 2 short absolute, 3 long absolute, 4 PC-relative, 5 memory-indirect, 6 and 7 reserved.

Top module: `ea_gen_top`

## Requirements
- R1: Mode 0 (post-increment): `ea_addr` equals `req_base`, `wb_data` equals `req_base` plus 1 for a byte (`req_word`=0) or plus 2 for a word (`req_word`=1), and `wb_en` is 1.
- R2: Mode 1 (pre-decrement): `ea_addr` and `wb_data` both equal `req_base` minus 1 (byte) or minus 2 (word), and `wb_en` is 1.
- R3: In modes 0 and 1, `align_err` is 1 exactly when `req_word` is 1 and bit 0 of `req_base` is 1. A byte access never sets it.
- R4: Mode 2 (short absolute): `ea_addr` is H'FF in the upper byte and `req_field[7:0]` in the lower byte.
- R5: Mode 3 (long absolute), and the reserved codes 6 and 7, give `ea_addr` = `req_field` unchanged, with no write-back and no alignment error.
- R6: Mode 4 (PC-relative): `ea_addr` = `req_pc` plus `req_field[7:0]` sign-extended to 16 bits, and `align_err` equals bit 0 of the displacement.
- R7: Mode 5 (memory-indirect): in the accept cycle `mem_rd_en` is 1 and `mem_addr` is {H'FF, `req_field[7:0]`}. The memory returns the word on `mem_rdata` in the next cycle, with the byte at the even address in bits 15:8. `done` rises two cycles after acceptance, with `ea_addr` equal to that word, `wb_en` 0, and `align_err` equal to bit 0 of the pointer field.
- R8: For the two cycles after a memory-indirect request is accepted, `req_ready` is 0. A request held valid during that time produces no `done` and no memory read.
- R9: For modes other than 5, `done` is 1 in the same cycle as an accepted request. `done` and `wb_en` are 0 in cycles with no request and no indirect completion. `wb_en` is 1 only for modes 0 and 1.
- R10: While reset (`rst_n` low) is held, `req_ready` is 1 and `done` and `mem_rd_en` are 0.
- R11: Address arithmetic wraps: a word post-increment of H'FFFE writes back H'0000, and a byte pre-decrement of H'0000 gives H'FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mode | input | 3 | Addressing-mode code |
| req_word | input | 1 | 1 = word operand, 0 = byte |
| req_base | input | 16 | Base register value |
| req_field | input | 16 | Absolute address or displacement field |
| req_pc | input | 16 | Program counter (instruction address + 2) |
| done | output | 1 | Result strobe |
| ea_addr | output | 16 | Effective address or branch target |
| wb_data | output | 16 | Register write-back value |
| wb_en | output | 1 | Register write-back enable |
| align_err | output | 1 | Odd word pointer or odd displacement |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd_en` |

## Verification
The assertions assume that the memory delivers data exactly one cycle after a read and that the requester keeps `req_mode`, `req_word` and `req_base` stable while `req_valid` is high in an accept cycle. Mode-dependent properties are checked only in cycles where a request is taken. The stimulus drives every input once per cycle at the falling edge. The bench memory model answers every read on the next rising edge. During indirect fetches, the bench holds competing requests valid with random contents to exercise the ignored-request rule.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  localparam int EA_AW = 16;
  localparam int EA_SW = 8;

  typedef enum logic [2:0] {
    EA_POSTINC = 3'd0,
    EA_PREDEC  = 3'd1,
    EA_ABS8    = 3'd2,
    EA_ABS16   = 3'd3,
    EA_PCREL   = 3'd4,
    EA_MEMIND  = 3'd5,
    EA_RSV6    = 3'd6,
    EA_RSV7    = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    IF_IDLE = 2'd0,
    IF_WAIT = 2'd1,
    IF_HOLD = 2'd2
  } ind_state_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_gen_pkg::*;
#(
  parameter int AW = EA_AW,
  parameter int SW = EA_SW,
  parameter logic [AW-SW-1:0] PAGE = '1
) (
  input  logic [2:0]    mode,
  input  logic          word,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] field,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_data,
  output logic          wb_en,
  output logic          align_err
);
  localparam int HW = AW - SW;

  logic [AW-1:0] step;
  logic [AW-1:0] bumped_up;
  logic [AW-1:0] bumped_dn;
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] paged;

  assign step      = {{(AW-2){1'b0}}, word, ~word};
  assign bumped_up = base + step;
  assign bumped_dn = base - step;
  assign disp_ext  = {{HW{field[SW-1]}}, field[SW-1:0]};
  assign paged     = {PAGE, field[SW-1:0]};

  always_comb begin
    addr      = field;
    wb_data   = base;
    wb_en     = 1'b0;
    align_err = 1'b0;
    case (mode)
      EA_POSTINC: begin
        addr      = base;
        wb_data   = bumped_up;
        wb_en     = 1'b1;
        align_err = word & base[0];
      end
      EA_PREDEC: begin
        addr      = bumped_dn;
        wb_data   = bumped_dn;
        wb_en     = 1'b1;
        align_err = word & base[0];
      end
      EA_ABS8:   addr = paged;
      EA_PCREL: begin
        addr      = pc + disp_ext;
        align_err = field[0];
      end
      EA_MEMIND: addr = paged;
      default:   addr = field;
    endcase
  end
endmodule

// File: rtl/ea_ind_fetch.sv
module ea_ind_fetch
  import ea_gen_pkg::*;
#(
  parameter int AW = EA_AW,
  parameter int SW = EA_SW,
  parameter logic [AW-SW-1:0] PAGE = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] ptr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] target,
  output logic          odd_ptr
);
  ind_state_e    state;
  logic [AW-1:0] tgt_q;
  logic          odd_q;

  assign mem_rd_en = start;
  assign mem_addr  = {PAGE, ptr};
  assign busy      = (state != IF_IDLE);
  assign done      = (state == IF_HOLD);
  assign target    = tgt_q;
  assign odd_ptr   = odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IF_IDLE;
      tgt_q <= '0;
      odd_q <= 1'b0;
    end else begin
      case (state)
        IF_IDLE: if (start) begin
          state <= IF_WAIT;
          odd_q <= ptr[0];
        end
        IF_WAIT: begin
          state <= IF_HOLD;
          tgt_q <= mem_rdata;
        end
        default: state <= IF_IDLE;
      endcase
    end
  end

  // R7
  ind_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_addr[AW-1:SW] == PAGE);

  // R8
  no_read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_rd_en);

  // R7
  ind_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done ##1 done);
endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top
  import ea_gen_pkg::*;
#(
  parameter int AW = EA_AW,
  parameter int SW = EA_SW,
  parameter logic [AW-SW-1:0] PAGE = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_mode,
  input  logic          req_word,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_field,
  input  logic [AW-1:0] req_pc,
  output logic          done,
  output logic [AW-1:0] ea_addr,
  output logic [AW-1:0] wb_data,
  output logic          wb_en,
  output logic          align_err,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] mem_rdata
);
  logic          accept;
  logic          is_ind;
  logic          quick;
  logic [AW-1:0] c_addr;
  logic [AW-1:0] c_wb;
  logic          c_wb_en;
  logic          c_err;
  logic          f_busy;
  logic          f_done;
  logic [AW-1:0] f_target;
  logic          f_odd;

  assign req_ready = ~f_busy;
  assign accept    = req_valid & req_ready;
  assign is_ind    = (req_mode == EA_MEMIND);
  assign quick     = accept & ~is_ind;

  ea_calc #(.AW(AW), .SW(SW), .PAGE(PAGE)) u_calc (
    .mode      (req_mode),
    .word      (req_word),
    .base      (req_base),
    .field     (req_field),
    .pc        (req_pc),
    .addr      (c_addr),
    .wb_data   (c_wb),
    .wb_en     (c_wb_en),
    .align_err (c_err)
  );

  ea_ind_fetch #(.AW(AW), .SW(SW), .PAGE(PAGE)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept & is_ind),
    .ptr       (req_field[SW-1:0]),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .busy      (f_busy),
    .done      (f_done),
    .target    (f_target),
    .odd_ptr   (f_odd)
  );

  assign done      = quick | f_done;
  assign ea_addr   = f_done ? f_target : c_addr;
  assign wb_data   = c_wb;
  assign wb_en     = quick & c_wb_en;
  assign align_err = f_done ? f_odd : (quick & c_err);

  // R9
  wb_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && req_valid && req_ready && req_mode <= 3'd1));

  // R8
  busy_after_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == EA_MEMIND) |=> !req_ready ##1 !req_ready);

  // R1
  postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == EA_POSTINC) |->
      (wb_en && ea_addr == req_base && (wb_data - ea_addr) == (req_word ? 16'd2 : 16'd1)));

  // R2
  predec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == EA_PREDEC) |->
      (wb_en && ea_addr == wb_data && (req_base - wb_data) == (req_word ? 16'd2 : 16'd1)));

  // R4
  short_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == EA_ABS8) |-> (done && ea_addr[AW-1:SW] == PAGE));

  // R3
  byte_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode <= 3'd1 && !req_word) |-> !align_err);
endmodule

// File: tb/tb_ea_gen_top.sv
module tb_ea_gen_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_mode;
  logic        req_word;
  logic [15:0] req_base, req_field, req_pc;
  logic        done;
  logic [15:0] ea_addr, wb_data;
  logic        wb_en, align_err, mem_rd_en;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_word(req_word), .req_base(req_base),
    .req_field(req_field), .req_pc(req_pc), .done(done), .ea_addr(ea_addr),
    .wb_data(wb_data), .wb_en(wb_en), .align_err(align_err),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, ~a[7:0]};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem_word(mem_addr);
  end

  function automatic logic [15:0] exp_addr(input logic [2:0] m, input logic w,
      input logic [15:0] b, input logic [15:0] f, input logic [15:0] p);
    logic [15:0] st = w ? 16'd2 : 16'd1;
    case (m)
      3'd0: return b;
      3'd1: return b - st;
      3'd2: return {8'hFF, f[7:0]};
      3'd4: return p + {{8{f[7]}}, f[7:0]};
      default: return f;
    endcase
  endfunction

  function automatic logic [15:0] exp_wb(input logic [2:0] m, input logic w, input logic [15:0] b);
    logic [15:0] st = w ? 16'd2 : 16'd1;
    return (m == 3'd0) ? b + st : b - st;
  endfunction

  function automatic logic exp_err(input logic [2:0] m, input logic w,
      input logic [15:0] b, input logic [15:0] f);
    if (m <= 3'd1) return w & b[0];
    if (m == 3'd4 || m == 3'd5) return f[0];
    return 1'b0;
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_req(input logic [2:0] m, input logic w, input logic [15:0] b,
      input logic [15:0] f, input logic [15:0] p, input string tg);
    string t = (tg == "") ? tag_of(m) : tg;
    string te = (m <= 3'd1) ? "R3" : t;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_word = w;
    req_base = b; req_field = f; req_pc = p;
    #1;
    if (m != 3'd5) begin
      check("R9", "done", {15'd0, done}, 16'd1);
      check(t, "addr", ea_addr, exp_addr(m, w, b, f, p));
      check("R9", "wb_en", {15'd0, wb_en}, {15'd0, (m <= 3'd1)});
      if (m <= 3'd1) check(t, "wb_data", wb_data, exp_wb(m, w, b));
      check(te, "align_err", {15'd0, align_err}, {15'd0, exp_err(m, w, b, f)});
    end else begin
      check("R7", "mem_rd_en", {15'd0, mem_rd_en}, 16'd1);
      check("R7", "mem_addr", mem_addr, {8'hFF, f[7:0]});
      check("R7", "early done", {15'd0, done}, 16'd0);
      @(negedge clk);
      req_mode = 3'($urandom_range(0, 5));
      req_word = 1'($urandom); req_base = 16'($urandom);
      req_field = 16'($urandom); req_pc = 16'($urandom);
      #1;
      check("R8", "ready busy", {15'd0, req_ready}, 16'd0);
      check("R8", "done busy", {15'd0, done}, 16'd0);
      check("R8", "read busy", {15'd0, mem_rd_en}, 16'd0);
      @(negedge clk);
      #1;
      check("R8", "ready hold", {15'd0, req_ready}, 16'd0);
      check("R7", "done", {15'd0, done}, 16'd1);
      check("R7", "target", ea_addr, mem_word({8'hFF, f[7:0]}));
      check("R7", "wb_en", {15'd0, wb_en}, 16'd0);
      check("R7", "align_err", {15'd0, align_err}, {15'd0, f[0]});
      check("R8", "read hold", {15'd0, mem_rd_en}, 16'd0);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    req_mode = 3'($urandom); req_base = 16'($urandom); req_field = 16'($urandom);
    #1;
    check("R9", "idle done", {15'd0, done}, 16'd0);
    check("R9", "idle wb_en", {15'd0, wb_en}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 3'd0; req_word = 1'b0;
    req_base = '0; req_field = '0; req_pc = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R10", "ready", {15'd0, req_ready}, 16'd1);
    check("R10", "done", {15'd0, done}, 16'd0);
    check("R10", "mem_rd_en", {15'd0, mem_rd_en}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    do_req(3'd0, 1'b1, 16'hFFFE, 16'h0000, 16'h0000, "R11");
    do_req(3'd1, 1'b0, 16'h0000, 16'h0000, 16'h0000, "R11");
    do_req(3'd0, 1'b1, 16'h1235, 16'h0000, 16'h0000, "R3");
    do_req(3'd1, 1'b0, 16'h1235, 16'h0000, 16'h0000, "R3");
    do_req(3'd2, 1'b0, 16'h0000, 16'h3412, 16'h0000, "R4");
    do_req(3'd3, 1'b1, 16'h0000, 16'hBEEF, 16'h0000, "R5");
    do_req(3'd6, 1'b0, 16'h0001, 16'h1357, 16'h0000, "R5");
    do_req(3'd4, 1'b0, 16'h0000, 16'h0080, 16'h0010, "R6");
    do_req(3'd4, 1'b0, 16'h0000, 16'h007F, 16'hFFF0, "R6");
    idle_check();
    do_req(3'd5, 1'b1, 16'h0000, 16'h0040, 16'h0000, "");
    do_req(3'd5, 1'b1, 16'h0000, 16'h00C1, 16'h0000, "");
    idle_check();

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m = 3'($urandom);
      do_req(m, 1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), "");
      if (($urandom % 8) == 0) idle_check();
    end
    idle_check();

    summary();
    $finish;
  end
endmodule